// File: doc/BRIEF.md
# Serial Flash Power-Mode and Status Front End

This block is the device-side command front end of a serial flash memory, as seen from an SPI host in mode 0. The SPI pins are brought into the system clock domain through two-stage synchronisers. The block then counts the serial clock edges of each chip-select frame, collects the opcode MSB first, and acts on three opcodes. A status read returns a byte assembled live from internal inputs. A sleep command moves the device into deep power-down. A wake command brings it back out.

Deep power-down is entered only when chip select rises after a frame of exactly eight bits carrying the sleep opcode. The entry then takes a fixed number of clock cycles. While the device is asleep, only the wake opcode is honoured. Leaving deep power-down takes a second fixed delay, during which the ready flag of the status byte reads busy. The compare result held in the status byte is sticky: it keeps its value until the next compare completes.

The SCK high and low phases must each last at least four system clock cycles.

Top module: `sflash_pm_front`

## Requirements
- R1: Opcode D7h (SI sampled on SCK rising edges, MSB first) starts a status read. The block then drives the status byte on SO, MSB first, updating after each SCK falling edge, with so_oe high. The byte repeats for as long as chip select stays low, and so_oe drops once chip select is high.
- R2: Status bit 7 is 1 (ready) when busy_i is low and the exit delay is not running, and 0 otherwise.
- R3: Status bit 6 takes the value of cmp_mismatch_i in every cycle where cmp_done_i is high. It holds that value in all other cycles.
- R4: Status bits 5 down to 2 always read 1111.
- R5: Status bit 1 is prot_sw_i OR prot_hw_i.
- R6: Status bit 0 is page_bin_i: 1 selects the 1024-byte page and 0 the 1056-byte page.
- R7: After reset the block is in standby: pd_o is 0, so_oe is 0 and the compare bit is 0.
- R8: From standby, a frame of exactly 8 bits carrying B9h starts the entry when chip select rises. pd_o rises ENTER_CYC clock cycles later, and not before.
- R9: A B9h frame cut short below 8 bits, or one longer than 8 bits, does not start deep power-down.
- R10: While pd_o is high, every opcode other than ABh has no effect. A status read leaves so_oe low, and a repeated B9h or any other code leaves pd_o high.
- R11: In deep power-down, a frame of exactly 8 bits carrying ABh drops pd_o when chip select rises. Status bit 7 then reads 0 for EXIT_CYC cycles, after which the block is back in standby.
- R12: While the entry delay runs, all opcodes are ignored, including a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High while SO carries status data |
| busy_i | input | 1 | Internal operation in progress |
| cmp_done_i | input | 1 | Pulse: a page-to-buffer compare has finished |
| cmp_mismatch_i | input | 1 | Result of that compare, 1 when any bit differed |
| prot_sw_i | input | 1 | Sector protection enabled by software |
| prot_hw_i | input | 1 | Sector protection enabled by the hardware pin |
| page_bin_i | input | 1 | Page-size setting, 1 for the binary page |
| pd_o | output | 1 | High while in deep power-down |

## Verification
The properties check the following on every cycle:
- SO is never driven while powered down.
- pd_o rises only at the end of the entry delay and falls only into the exit phase.
- The entry delay cannot be cut short.
- so_oe drops after chip select rises.
- The compare bit loads and holds as specified.

Only the bench scenarios can show the values of the status byte fields. The same holds for the exact entry latency, the rejection of short and long frames, and the busy reading during exit, because each depends on a whole serial frame and on values driven from outside.

// File: rtl/sflash_pm_front.sv
module sflash_pm_front #(
  parameter int ENTER_CYC = 64,
  parameter int EXIT_CYC = 32,
  parameter logic [7:0] OP_STATUS = 8'hD7,
  parameter logic [7:0] OP_SLEEP = 8'hB9,
  parameter logic [7:0] OP_WAKE = 8'hAB,
  parameter logic [3:0] DENSITY = 4'hF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe,
  input  logic busy_i,
  input  logic cmp_done_i,
  input  logic cmp_mismatch_i,
  input  logic prot_sw_i,
  input  logic prot_hw_i,
  input  logic page_bin_i,
  output logic pd_o
);
  localparam int MAXC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int TW = $clog2(MAXC + 1);
  localparam logic [1:0] ST_STBY = 2'd0, ST_ENTER = 2'd1, ST_DPD = 2'd2, ST_EXIT = 2'd3;

  logic [1:0] cs_q, sck_q, si_q;
  logic cs_d, sck_d;
  logic [3:0] bcnt;
  logic [6:0] op_sr;
  logic [7:0] op_q;
  logic [1:0] state;
  logic [TW-1:0] timer;
  logic rd_act;
  logic [2:0] ocnt;
  logic [6:0] out_sr;
  logic so_q;
  logic cmp_q;

  wire cs_s = cs_q[1];
  wire sck_s = sck_q[1];
  wire si_s = si_q[1];
  wire sck_rise = ~cs_s & sck_s & ~sck_d;
  wire sck_fall = ~cs_s & ~sck_s & sck_d;
  wire cs_rise = cs_s & ~cs_d;
  wire [7:0] op_now = {op_sr, si_s};
  wire op_done = sck_rise && (bcnt == 4'd7);
  wire full_op = (bcnt == 4'd8);
  wire rd_ok = (state == ST_STBY) || (state == ST_EXIT);
  wire [7:0] status = {~busy_i & (state != ST_EXIT), cmp_q, DENSITY,
                       prot_sw_i | prot_hw_i, page_bin_i};

  assign so = so_q & rd_act;
  assign so_oe = rd_act;
  assign pd_o = (state == ST_DPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11;
      sck_q <= 2'b00;
      si_q <= 2'b00;
      cs_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      sck_q <= {sck_q[0], sck};
      si_q <= {si_q[0], si};
      cs_d <= cs_s;
      sck_d <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      op_sr <= '0;
      op_q <= '0;
      rd_act <= 1'b0;
    end else if (cs_s) begin
      bcnt <= '0;
      rd_act <= 1'b0;
    end else if (sck_rise) begin
      if (bcnt != 4'd9) bcnt <= bcnt + 4'd1;
      if (bcnt < 4'd7) op_sr <= {op_sr[5:0], si_s};
      if (op_done) begin
        op_q <= op_now;
        if (op_now == OP_STATUS && rd_ok) rd_act <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt <= '0;
      out_sr <= '0;
      so_q <= 1'b0;
    end else if (!rd_act) begin
      ocnt <= '0;
      so_q <= 1'b0;
    end else if (sck_fall) begin
      if (ocnt == 3'd0) {so_q, out_sr} <= status;
      else {so_q, out_sr} <= {out_sr, 1'b0};
      ocnt <= ocnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_STBY;
      timer <= '0;
    end else begin
      case (state)
        ST_STBY:
          if (cs_rise && full_op && op_q == OP_SLEEP) begin
            state <= ST_ENTER;
            timer <= TW'(ENTER_CYC - 1);
          end
        ST_ENTER:
          if (timer == '0) state <= ST_DPD;
          else timer <= timer - TW'(1);
        ST_DPD:
          if (cs_rise && full_op && op_q == OP_WAKE) begin
            state <= ST_EXIT;
            timer <= TW'(EXIT_CYC - 1);
          end
        default:
          if (timer == '0) state <= ST_STBY;
          else timer <= timer - TW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else if (cmp_done_i) cmp_q <= cmp_mismatch_i;
  end
endmodule

// File: rtl/sflash_pm_front_chk.sv
module sflash_pm_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic [1:0] state,
  input logic pd_o,
  input logic so_oe,
  input logic cmp_done_i,
  input logic cmp_mismatch_i,
  input logic cmp_q
);
  // R10
  no_read_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n) pd_o |-> !so_oe);
  // R8
  enter_path_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pd_o) |-> $past(state) == 2'd1);
  // R11
  wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(pd_o) |-> state == 2'd3);
  // R12
  enter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) state == 2'd1 |=> (state == 2'd1 || state == 2'd2));
  // R1
  read_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !so_oe);
  // R3
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n) cmp_done_i |=> cmp_q == $past(cmp_mismatch_i));
  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !cmp_done_i |=> $stable(cmp_q));
endmodule

bind sflash_pm_front sflash_pm_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state(state), .pd_o(pd_o), .so_oe(so_oe),
  .cmp_done_i(cmp_done_i), .cmp_mismatch_i(cmp_mismatch_i), .cmp_q(cmp_q)
);

// File: tb/sflash_pm_front_tb.sv
`timescale 1ns/1ps
module sflash_pm_front_tb_top;
  localparam int ENTER_CYC = 300;
  localparam int EXIT_CYC = 400;
  localparam int H = 5;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic busy_i = 0, cmp_done_i = 0, cmp_mismatch_i = 0, prot_sw_i = 0, prot_hw_i = 0, page_bin_i = 0;
  logic so, so_oe, pd_o;
  int checks = 0, errors = 0;
  bit oe_seen = 0;

  always #10 clk = ~clk;

  sflash_pm_front #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .busy_i(busy_i), .cmp_done_i(cmp_done_i), .cmp_mismatch_i(cmp_mismatch_i),
    .prot_sw_i(prot_sw_i), .prot_hw_i(prot_hw_i), .page_bin_i(page_bin_i), .pd_o(pd_o)
  );

  // behavioural reference model: inputs reach the logic two clocks late
  bit qc[$], qk[$], qs[$];
  int m_state = 0, m_timer = 0, m_bits = 0, m_op = 0, m_rd = 0, m_ocnt = 0, m_obyte = 0, m_so = 0, m_cmp = 0;
  bit p_cs = 1, p_sck = 0;
  bit exp_pd = 0, exp_oe = 0, exp_so = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      qc.delete(); qk.delete(); qs.delete();
      m_state = 0; m_timer = 0; m_bits = 0; m_op = 0; m_rd = 0; m_ocnt = 0; m_so = 0; m_cmp = 0;
      p_cs = 1; p_sck = 0;
    end else begin
      qc.push_back(cs_n); qk.push_back(sck); qs.push_back(si);
      if (qc.size() > 2) begin
        bit c, k, s, rise, fall, csr;
        int st, rd_old, bits_old;
        c = qc.pop_front(); k = qk.pop_front(); s = qs.pop_front();
        rise = !c && k && !p_sck;
        fall = !c && !k && p_sck;
        csr = c && !p_cs;
        st = ((!busy_i && m_state != 3) ? 128 : 0) + m_cmp * 64 + 60
             + ((prot_sw_i || prot_hw_i) ? 2 : 0) + (page_bin_i ? 1 : 0);
        rd_old = m_rd; bits_old = m_bits;
        case (m_state)
          0: if (csr && bits_old == 8 && m_op == 'hB9) begin m_state = 1; m_timer = ENTER_CYC - 1; end
          1: if (m_timer == 0) m_state = 2; else m_timer--;
          2: if (csr && bits_old == 8 && m_op == 'hAB) begin m_state = 3; m_timer = EXIT_CYC - 1; end
          default: if (m_timer == 0) m_state = 0; else m_timer--;
        endcase
        if (c) begin m_bits = 0; m_rd = 0; m_op = 0; end
        else if (rise) begin
          if (bits_old < 8) m_op = ((m_op << 1) | s) & 255;
          if (bits_old == 7 && m_op == 'hD7 && (m_state == 0 || m_state == 3)) m_rd = 1;
          if (bits_old < 9) m_bits = bits_old + 1;
        end
        if (!rd_old) begin m_ocnt = 0; m_so = 0; end
        else if (fall) begin
          if (m_ocnt == 0) m_obyte = st;
          m_so = (m_obyte >> (7 - m_ocnt)) & 1;
          m_ocnt = (m_ocnt + 1) % 8;
        end
        p_cs = c; p_sck = k;
      end
      if (cmp_done_i) m_cmp = cmp_mismatch_i;
    end
    exp_pd = (m_state == 2);
    exp_oe = (m_rd != 0);
    exp_so = (m_rd != 0) && (m_so != 0);
  end

  always @(negedge clk) begin
    if (so_oe) oe_seen = 1;
    if (rst_n) begin
      checks++;
      if (pd_o !== exp_pd || so_oe !== exp_oe || so !== exp_so) begin
        errors++;
        $display("FAIL R1/R8 model actual pd=%b oe=%b so=%b expected pd=%b oe=%b so=%b",
                 pd_o, so_oe, so, exp_pd, exp_oe, exp_so);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = 0;
    for (int i = 0; i < nb; i++) begin
      sck = 0; si = (i < 8) ? b[7-i] : 1'b1;
      wait_n(H);
      r = {r[6:0], so};
      sck = 1;
      wait_n(H);
    end
    sck = 0;
  endtask

  task automatic frame_cmd(input logic [7:0] op, input int nb);
    logic [7:0] r;
    cs_n = 0; wait_n(H);
    xfer(op, nb, r);
    wait_n(H); cs_n = 1; wait_n(4 * H);
  endtask

  task automatic read_stat(output logic [7:0] b0, output logic [7:0] b1);
    logic [7:0] r;
    cs_n = 0; wait_n(H);
    xfer(8'hD7, 8, r);
    xfer(8'h00, 8, b0);
    xfer(8'h00, 8, b1);
    wait_n(H); cs_n = 1; wait_n(4 * H);
  endtask

  function automatic int exp_stat(input bit rdy);
    return {rdy, dut_cmp_model(), 4'hF, prot_sw_i | prot_hw_i, page_bin_i};
  endfunction

  bit cmp_ref = 0;
  function automatic bit dut_cmp_model();
    return cmp_ref;
  endfunction

  task automatic cmp_pulse(input bit mm);
    cmp_mismatch_i = mm; cmp_done_i = 1; wait_n(1);
    cmp_done_i = 0; cmp_mismatch_i = ~mm; cmp_ref = mm; wait_n(2);
  endtask

  initial begin
    logic [7:0] a, b;
    wait_n(5); rst_n = 1; wait_n(2);
    chk("R7 pd after reset", pd_o, 0);
    chk("R7 so_oe after reset", so_oe, 0);
    read_stat(a, b);
    chk("R4 R7 status idle", a, exp_stat(1));
    chk("R1 status repeats", b, a);
    busy_i = 1; page_bin_i = 1;
    read_stat(a, b);
    chk("R2 busy bit", a, exp_stat(0));
    chk("R6 page bit", b, 8'h3D);
    busy_i = 0; page_bin_i = 0; prot_sw_i = 1;
    read_stat(a, b);
    chk("R5 software protect", a, 8'hBE);
    prot_sw_i = 0; prot_hw_i = 1;
    read_stat(a, b);
    chk("R5 hardware protect", a, 8'hBE);
    prot_hw_i = 0;
    cmp_pulse(1);
    read_stat(a, b);
    chk("R3 mismatch sticky", a, 8'hFC);
    cmp_pulse(0);
    read_stat(a, b);
    chk("R3 match clears", a, exp_stat(1));
    frame_cmd(8'hB9, 7); wait_n(ENTER_CYC + 20);
    chk("R9 short frame", pd_o, 0);
    frame_cmd(8'hB9, 9); wait_n(ENTER_CYC + 20);
    chk("R9 long frame", pd_o, 0);
    frame_cmd(8'hB9, 8);
    chk("R8 not yet asleep", pd_o, 0);
    oe_seen = 0;
    cs_n = 0; wait_n(H); xfer(8'hD7, 8, a); xfer(8'h00, 8, a); wait_n(H); cs_n = 1; wait_n(H);
    chk("R12 read ignored in entry", oe_seen, 0);
    chk("R8 still entering", pd_o, 0);
    wait_n(150);
    chk("R8 asleep", pd_o, 1);
    oe_seen = 0;
    read_stat(a, b);
    chk("R10 read ignored asleep", oe_seen, 0);
    frame_cmd(8'hB9, 8); frame_cmd(8'h12, 8); frame_cmd(8'hAB, 7);
    chk("R10 other opcodes ignored", pd_o, 1);
    frame_cmd(8'hAB, 8);
    chk("R11 wake drops pd", pd_o, 0);
    read_stat(a, b);
    chk("R11 busy during exit", a, exp_stat(0));
    wait_n(EXIT_CYC);
    read_stat(a, b);
    chk("R11 ready after exit", a, exp_stat(1));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule